// File: doc/BRIEF.md
# Banked Interrupt Controller with Fast-Interrupt Routing

This block gathers 64 level-sensitive peripheral request lines and 8 level-sensitive local request lines. It presents them to a processor as one normal interrupt output (`irq_o`) and one fast-interrupt output (`fiq_o`). Each source has an enable bit. Software never writes the enable masks directly. It changes them through write-one-to-set and write-one-to-clear registers, so a driver can change its own bits without a read-modify-write. Each pending state follows its input line. Nothing is latched, so a source stays pending only while its line is high.

A summary word gives a fast view of the sources in one read. It holds the enabled local sources and an any-pending flag for each 32-bit peripheral half. It also holds copies of eleven frequently serviced peripheral lines. The fast-interrupt path picks a single raw line by index and ignores the enable masks. A 32-bit word-wide register port gives access to all registers. Reads are combinational, and a write takes effect at the next clock edge.

Top module: `bic_ctrl`

## Requirements
- R1: Peripheral pending words return the line levels ANDed with the enable mask. Byte offset 0x04 holds sources 0–31 (bit n = source n). Offset 0x08 holds sources 32–63 (bit n = source 32+n).
- R2: A write to offset 0x10, 0x14 or 0x18 sets the enable bits where the data has ones and leaves the others unchanged. These offsets cover peripheral 0–31, peripheral 32–63 and local 0–7.
- R3: A write to offset 0x1C, 0x20 or 0x24 clears the enable bits where the data has ones, in the same group order as R2.
- R4: For the local-source set and clear registers, only data bits 7:0 take effect.
- R5: Reading a set register returns the current mask. Reading a clear register returns the bitwise inverse of the mask, zero-extended to 32 bits before inversion for the local group.
- R6: The summary word at offset 0x00 holds the following fields. Bits 7:0 are the enabled pending local sources. Bit 8 is set when any enabled peripheral source 0–31 is pending, and bit 9 when any enabled source 32–63 is pending. Bits 20:10 hold the enabled pending state of peripheral sources 7, 9, 10, 18, 19, 53, 54, 55, 56, 57 and 62, in that order from bit 10 upward. Bits 31:21 read 0.
- R7: The fast-interrupt control word at offset 0x0C stores the select in bits 6:0 and the enable in bit 7. It reads them back in the same positions, with bits 31:8 reading 0.
- R8: With the fast path enabled, select 0–63 drives `fiq_o` from that peripheral line and select 64–71 from local line (select−64), whatever the enable masks hold. A select of 72–127, or a disabled fast path, gives `fiq_o` = 0.
- R9: `irq_o` is high exactly when some peripheral or local source is both high and enabled.
- R10: Reset clears both enable masks, the fast enable and the fast select.
- R11: Reads of unmapped or misaligned offsets return 0. Writes to them, or to offsets 0x00, 0x04 and 0x08, change no state.
- R12: `irq_o`, `fiq_o` and read data respond combinationally to the line levels. A register write becomes visible only after the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| periph_lvl_i | input | 64 | Peripheral request levels |
| local_lvl_i | input | 8 | Local request levels |
| addr_i | input | 9 | Byte address of the register access |
| wr_en_i | input | 1 | Write strobe, sampled at the rising edge |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Combinational read data for `addr_i` |
| irq_o | output | 1 | Normal interrupt output |
| fiq_o | output | 1 | Fast interrupt output |

## Verification
The bench sweeps every fast-select value, both enabled and disabled. At each value it drives a pattern in which only the selected line is high and a pattern in which only that line is low. A mux off by one, or a select range that wraps past 71, would then raise `fiq_o` on the wrong source or on an out-of-range select. Randomised set and clear writes run over random line levels, and every register is checked against an arithmetic model after each write. This catches set writes that overwrite the mask instead of OR-ing into it. It also catches local writes that leak upper data bits, and clear-register reads that are not inverted or not extended over 32 bits. A summary copy taken from the wrong source shows up as a bad bit in 20:10. Write-timing and unmapped-access probes expose a write that is visible in the same cycle, and a decode that aliases on the upper address bits.

// File: rtl/bic_pkg.sv
package bic_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned N_PERIPH = 64;
  localparam int unsigned N_LOCAL  = 8;
  localparam int unsigned SEL_W    = 7;
  localparam int unsigned N_COPY   = 11;
  localparam int unsigned N_WORDS  = N_PERIPH / DATA_W;

  typedef enum logic [3:0] {
    REG_SUMMARY = 4'd0,
    REG_PEND_LO = 4'd1,
    REG_PEND_HI = 4'd2,
    REG_FIQ     = 4'd3,
    REG_SET_LO  = 4'd4,
    REG_SET_HI  = 4'd5,
    REG_SET_LOC = 4'd6,
    REG_CLR_LO  = 4'd7,
    REG_CLR_HI  = 4'd8,
    REG_CLR_LOC = 4'd9,
    REG_NONE    = 4'd15
  } reg_sel_e;

  localparam int unsigned N_REGS = 10;

  typedef struct packed {
    logic             en;
    logic [SEL_W-1:0] sel;
  } fiq_cfg_t;

  // Peripheral source mirrored into summary bit (10 + k).
  function automatic int unsigned copy_src(int unsigned k);
    case (k)
      0:       return 7;
      1:       return 9;
      2:       return 10;
      3:       return 18;
      4:       return 19;
      5:       return 53;
      6:       return 54;
      7:       return 55;
      8:       return 56;
      9:       return 57;
      default: return 62;
    endcase
  endfunction
endpackage

// File: rtl/bic_decode.sv
module bic_decode
  import bic_pkg::*;
#(
  parameter int unsigned ADDR_W = 9
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              aligned;

  assign word    = addr_i[ADDR_W-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);

  always_comb begin
    sel_o = REG_NONE;
    if (aligned && (word < WORD_W'(N_REGS))) begin
      sel_o = reg_sel_e'(word[3:0]);
    end
  end
endmodule

// File: rtl/bic_mask_reg.sv
module bic_mask_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q;
  logic [W-1:0] mask_d;
  logic         upd;

  always_comb begin
    upd    = (|set_i) | (|clr_i);
    mask_d = (mask_q | set_i) & ~clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (upd) begin
      mask_q <= mask_d;
    end
  end

  assign mask_o = mask_q;

  // R2: requested bits are set after the edge
  a_r2_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    ((|set_i) && !(|clr_i)) |=> ((mask_q & $past(set_i)) == $past(set_i)));

  // R3: requested bits are cleared after the edge
  a_r3_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_i) |=> ((mask_q & $past(clr_i)) == '0));

  // R11: no request, no change
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|set_i) && !(|clr_i)) |=> $stable(mask_q));
endmodule

// File: rtl/bic_fiq_route.sv
module bic_fiq_route
  import bic_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_i,
  input  logic [SEL_W:0]      wdata_i,
  input  logic [N_PERIPH-1:0] periph_i,
  input  logic [N_LOCAL-1:0]  local_i,
  output fiq_cfg_t            cfg_o,
  output logic                fiq_o
);
  localparam int unsigned PER_IW = $clog2(N_PERIPH);
  localparam int unsigned LOC_IW = $clog2(N_LOCAL);
  localparam int unsigned LAST_SRC = N_PERIPH + N_LOCAL;

  fiq_cfg_t cfg_q;
  fiq_cfg_t cfg_d;

  always_comb begin
    cfg_d = wr_i ? fiq_cfg_t'(wdata_i) : cfg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_i) begin
      cfg_q <= cfg_d;
    end
  end

  // Peripheral count is a multiple of the local count, so the local
  // offset is the low bits of the select.
  always_comb begin
    fiq_o = 1'b0;
    if (cfg_q.en) begin
      if (cfg_q.sel < SEL_W'(N_PERIPH)) begin
        fiq_o = periph_i[cfg_q.sel[PER_IW-1:0]];
      end else if (cfg_q.sel < SEL_W'(LAST_SRC)) begin
        fiq_o = local_i[cfg_q.sel[LOC_IW-1:0]];
      end
    end
  end

  assign cfg_o = cfg_q;

  // R7: control word stored on write
  a_r7_store: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (cfg_q == $past(wdata_i)));

  // R8: disabled path is quiet
  a_r8_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_o.en |-> !fiq_o);

  // R8: selects past the last source are quiet
  a_r8_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_o.sel >= SEL_W'(LAST_SRC)) |-> !fiq_o);
endmodule

// File: rtl/bic_readmux.sv
module bic_readmux
  import bic_pkg::*;
(
  input  reg_sel_e            sel_i,
  input  logic [N_PERIPH-1:0] pmask_i,
  input  logic [N_LOCAL-1:0]  lmask_i,
  input  logic [N_PERIPH-1:0] periph_i,
  input  logic [N_LOCAL-1:0]  local_i,
  input  fiq_cfg_t            cfg_i,
  output logic [DATA_W-1:0]   summary_o,
  output logic [DATA_W-1:0]   rd_data_o
);
  localparam int unsigned ANY_LO_BIT = N_LOCAL;
  localparam int unsigned ANY_HI_BIT = N_LOCAL + 1;
  localparam int unsigned COPY_BASE  = N_LOCAL + 2;

  logic [N_PERIPH-1:0] ppend;
  logic [N_LOCAL-1:0]  lpend;
  logic [DATA_W-1:0]   lmask_ext;

  assign ppend     = periph_i & pmask_i;
  assign lpend     = local_i & lmask_i;
  assign lmask_ext = {{(DATA_W-N_LOCAL){1'b0}}, lmask_i};

  always_comb begin
    summary_o                 = '0;
    summary_o[N_LOCAL-1:0]    = lpend;
    summary_o[ANY_LO_BIT]     = |ppend[DATA_W-1:0];
    summary_o[ANY_HI_BIT]     = |ppend[N_PERIPH-1:DATA_W];
    for (int unsigned k = 0; k < N_COPY; k++) begin
      summary_o[COPY_BASE+k] = ppend[copy_src(k)];
    end
  end

  always_comb begin
    case (sel_i)
      REG_SUMMARY: rd_data_o = summary_o;
      REG_PEND_LO: rd_data_o = ppend[DATA_W-1:0];
      REG_PEND_HI: rd_data_o = ppend[N_PERIPH-1:DATA_W];
      REG_FIQ:     rd_data_o = {{(DATA_W-SEL_W-1){1'b0}}, cfg_i};
      REG_SET_LO:  rd_data_o = pmask_i[DATA_W-1:0];
      REG_SET_HI:  rd_data_o = pmask_i[N_PERIPH-1:DATA_W];
      REG_SET_LOC: rd_data_o = lmask_ext;
      REG_CLR_LO:  rd_data_o = ~pmask_i[DATA_W-1:0];
      REG_CLR_HI:  rd_data_o = ~pmask_i[N_PERIPH-1:DATA_W];
      REG_CLR_LOC: rd_data_o = ~lmask_ext;
      default:     rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/bic_ctrl.sv
module bic_ctrl
  import bic_pkg::*;
#(
  parameter int unsigned ADDR_W = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_PERIPH-1:0] periph_lvl_i,
  input  logic [N_LOCAL-1:0]  local_lvl_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_en_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  output logic [DATA_W-1:0]   rd_data_o,
  output logic                irq_o,
  output logic                fiq_o
);
  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync_q[1];

  reg_sel_e            sel;
  logic [N_PERIPH-1:0] pmask;
  logic [N_LOCAL-1:0]  lmask;
  fiq_cfg_t            cfg;
  logic [DATA_W-1:0]   summary;

  bic_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  // Peripheral enable banks, one per data word
  for (genvar w = 0; w < N_WORDS; w++) begin : g_pbank
    localparam reg_sel_e SET_ID = (w == 0) ? REG_SET_LO : REG_SET_HI;
    localparam reg_sel_e CLR_ID = (w == 0) ? REG_CLR_LO : REG_CLR_HI;
    logic [DATA_W-1:0] set_w;
    logic [DATA_W-1:0] clr_w;

    assign set_w = (wr_en_i && (sel == SET_ID)) ? wr_data_i : '0;
    assign clr_w = (wr_en_i && (sel == CLR_ID)) ? wr_data_i : '0;

    bic_mask_reg #(.W(DATA_W)) u_mask (
      .clk    (clk),
      .rst_n  (rst_n_int),
      .set_i  (set_w),
      .clr_i  (clr_w),
      .mask_o (pmask[w*DATA_W +: DATA_W])
    );
  end

  logic [N_LOCAL-1:0] lset;
  logic [N_LOCAL-1:0] lclr;

  assign lset = (wr_en_i && (sel == REG_SET_LOC)) ? wr_data_i[N_LOCAL-1:0] : '0;
  assign lclr = (wr_en_i && (sel == REG_CLR_LOC)) ? wr_data_i[N_LOCAL-1:0] : '0;

  bic_mask_reg #(.W(N_LOCAL)) u_lmask (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .set_i  (lset),
    .clr_i  (lclr),
    .mask_o (lmask)
  );

  bic_fiq_route u_fiq (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .wr_i     (wr_en_i && (sel == REG_FIQ)),
    .wdata_i  (wr_data_i[SEL_W:0]),
    .periph_i (periph_lvl_i),
    .local_i  (local_lvl_i),
    .cfg_o    (cfg),
    .fiq_o    (fiq_o)
  );

  bic_readmux u_rd (
    .sel_i     (sel),
    .pmask_i   (pmask),
    .lmask_i   (lmask),
    .periph_i  (periph_lvl_i),
    .local_i   (local_lvl_i),
    .cfg_i     (cfg),
    .summary_o (summary),
    .rd_data_o (rd_data_o)
  );

  assign irq_o = (|(periph_lvl_i & pmask)) | (|(local_lvl_i & lmask));

  // R9: interrupt output agrees with the summary's pending flags
  a_r9_irq_summary: assert property (@(posedge clk) disable iff (!rst_n_int)
    irq_o == (|summary[N_LOCAL+1:0]));

  // R11: writes that miss every writable register leave the masks alone
  a_r11_no_side_effect: assert property (@(posedge clk) disable iff (!rst_n_int)
    (wr_en_i && ((sel == REG_NONE) || (sel == REG_SUMMARY) ||
                 (sel == REG_PEND_LO) || (sel == REG_PEND_HI)))
    |=> ($stable(pmask) && $stable(lmask) && $stable(cfg)));
endmodule

// File: tb/bic_ctrl_tb.sv
`timescale 1ns/1ps
module bic_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] plvl = '0;
  logic [7:0]  llvl = '0;
  logic [8:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_data;
  logic        irq, fiq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  // model state
  logic [63:0] m_pm = '0;
  logic [7:0]  m_lm = '0;
  logic [6:0]  m_sel = '0;
  logic        m_fen = 1'b0;
  int dup[11] = '{7, 9, 10, 18, 19, 53, 54, 55, 56, 57, 62};

  always #4 clk = ~clk;

  bic_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .periph_lvl_i(plvl), .local_lvl_i(llvl),
    .addr_i(addr), .wr_en_i(wr_en), .wr_data_i(wdata),
    .rd_data_o(rd_data), .irq_o(irq), .fiq_o(fiq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_chk(string req, logic [8:0] a, logic [31:0] exp);
    @(negedge clk);
    addr = a; wr_en = 1'b0;
    #1;
    chk(req, rd_data, exp);
  endtask

  task automatic wr(logic [8:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    case (a)
      9'h0C: begin m_sel = d[6:0]; m_fen = d[7]; end
      9'h10: m_pm[31:0]  = m_pm[31:0] | d;
      9'h14: m_pm[63:32] = m_pm[63:32] | d;
      9'h18: m_lm        = m_lm | d[7:0];
      9'h1C: m_pm[31:0]  = m_pm[31:0] & ~d;
      9'h20: m_pm[63:32] = m_pm[63:32] & ~d;
      9'h24: m_lm        = m_lm & ~d[7:0];
      default: ;
    endcase
  endtask

  function automatic logic [31:0] exp_sum();
    logic [63:0] pp = plvl & m_pm;
    logic [31:0] s = '0;
    s[7:0] = llvl & m_lm;
    s[8] = |pp[31:0];
    s[9] = |pp[63:32];
    for (int k = 0; k < 11; k++) s[10+k] = pp[dup[k]];
    return s;
  endfunction

  function automatic logic exp_fiq();
    if (!m_fen) return 1'b0;
    if (m_sel < 64) return plvl[m_sel];
    if (m_sel < 72) return llvl[m_sel-64];
    return 1'b0;
  endfunction

  task automatic check_all(string tag);
    logic [63:0] pp;
    pp = plvl & m_pm;
    rd_chk({"R6 ", tag}, 9'h00, exp_sum());
    chk({"R1 lo ", tag}, 32'(0), 32'(0));
    rd_chk({"R1 lo ", tag}, 9'h04, pp[31:0]);
    rd_chk({"R1 hi ", tag}, 9'h08, pp[63:32]);
    rd_chk({"R7 ", tag}, 9'h0C, {24'h0, m_fen, m_sel});
    rd_chk({"R5 set lo ", tag}, 9'h10, m_pm[31:0]);
    rd_chk({"R5 set hi ", tag}, 9'h14, m_pm[63:32]);
    rd_chk({"R5 set loc ", tag}, 9'h18, {24'h0, m_lm});
    rd_chk({"R5 clr lo ", tag}, 9'h1C, ~m_pm[31:0]);
    rd_chk({"R5 clr hi ", tag}, 9'h20, ~m_pm[63:32]);
    rd_chk({"R5 clr loc ", tag}, 9'h24, ~{24'h0, m_lm});
    chk({"R9 ", tag}, 32'(irq), 32'((|pp) | (|(llvl & m_lm))));
    chk({"R8 ", tag}, 32'(fiq), 32'(exp_fiq()));
  endtask

  initial begin
    #1_600_000;
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [8:0] ra;
    logic [31:0] rdv;
    plvl = 64'hFFFF_FFFF_FFFF_FFFF;
    llvl = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: reset state, all lines high so any enable would show
    check_all("R10 reset");

    // R2 / R3 / R4 directed
    wr(9'h18, 32'hFFFF_FF0F);
    rd_chk("R4 set loc low byte only", 9'h18, 32'h0000_000F);
    wr(9'h24, 32'hFFFF_FF00);
    rd_chk("R4 clr loc ignores upper bits", 9'h18, 32'h0000_000F);
    wr(9'h10, 32'h0000_00F0);
    wr(9'h10, 32'h0000_0003);
    rd_chk("R2 set accumulates", 9'h10, 32'h0000_00F3);
    wr(9'h1C, 32'h0000_0011);
    rd_chk("R3 clear selected bits", 9'h10, 32'h0000_00E2);

    // R12: write not visible before edge, visible after
    @(negedge clk);
    addr = 9'h14; wdata = 32'h8000_0001; wr_en = 1'b1;
    #1 chk("R12 before edge", rd_data, m_pm[63:32]);
    @(posedge clk);
    #1 chk("R12 after edge", rd_data, m_pm[63:32] | 32'h8000_0001);
    @(negedge clk);
    wr_en = 1'b0;
    m_pm[63:32] = m_pm[63:32] | 32'h8000_0001;
    // R12: outputs follow lines with no clock
    plvl = '0; llvl = '0;
    #1 chk("R12 irq comb low", 32'(irq), 32'(0));
    plvl[63] = 1'b1;
    #1 chk("R12 irq comb high", 32'(irq), 32'(1));

    // Random sweep of set/clear writes against random line levels
    for (int it = 0; it < 300; it++) begin
      logic [8:0] a;
      case ($urandom_range(0, 5))
        0: a = 9'h10; 1: a = 9'h14; 2: a = 9'h18;
        3: a = 9'h1C; 4: a = 9'h20; default: a = 9'h24;
      endcase
      plvl = {$urandom, $urandom};
      llvl = 8'($urandom);
      wr(a, $urandom & $urandom);
      if (it % 4 == 0) wr(9'h0C, 32'($urandom));
      check_all("R1 R2 R3 R6 random");
    end

    // Summary copies: each mirrored line alone, all enabled (R6)
    wr(9'h10, 32'hFFFF_FFFF); wr(9'h14, 32'hFFFF_FFFF); wr(9'h18, 32'hFF);
    llvl = '0;
    for (int k = 0; k < 11; k++) begin
      plvl = '0;
      plvl[dup[k]] = 1'b1;
      rd_chk("R6 copy bit", 9'h00,
             (32'h1 << (10 + k)) | (dup[k] < 32 ? 32'h100 : 32'h200));
    end

    // R8 exhaustive select sweep, enables both full and empty
    for (int pass = 0; pass < 2; pass++) begin
      if (pass == 1) begin
        wr(9'h1C, 32'hFFFF_FFFF); wr(9'h20, 32'hFFFF_FFFF); wr(9'h24, 32'hFF);
      end
      for (int s = 0; s < 128; s++) begin
        for (int en = 0; en < 2; en++) begin
          logic exp1;
          wr(9'h0C, 32'(s) | (en ? 32'h80 : 32'h0));
          plvl = '0; llvl = '0;
          if (s < 64) plvl[s] = 1'b1; else if (s < 72) llvl[s-64] = 1'b1;
          exp1 = (en == 1) && (s < 72);
          #1 chk("R8 selected line high", 32'(fiq), 32'(exp1));
          plvl = ~plvl; llvl = ~llvl;
          #1 chk("R8 others high", 32'(fiq), 32'(0));
        end
      end
    end

    // R11: unmapped and misaligned reads/writes
    wr(9'h10, 32'h1234_5678); wr(9'h18, 32'h5A);
    wr(9'h0C, 32'h0000_0085);
    plvl = {$urandom, $urandom}; llvl = 8'($urandom);
    for (int a = 9'h28; a < 9'h200; a += 4) begin
      ra = 9'(a);
      rd_chk("R11 unmapped read", ra, 32'h0);
    end
    rd_chk("R11 misaligned read", 9'h11, 32'h0);
    wr(9'h00, 32'hFFFF_FFFF);
    wr(9'h04, 32'hFFFF_FFFF);
    wr(9'h08, 32'hFFFF_FFFF);
    wr(9'h11, 32'hFFFF_FFFF);
    wr(9'h1D, 32'hFFFF_FFFF);
    wr(9'h50, 32'hFFFF_FFFF);
    wr(9'h110, 32'hFFFF_FFFF);
    wr(9'h11C, 32'hFFFF_FFFF);
    wr(9'h10C, 32'h0000_0000);
    check_all("R11 after ignored writes");

    // R10: reset again after state was programmed
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_pm = '0; m_lm = '0; m_sel = '0; m_fen = 1'b0;
    plvl = '1; llvl = '1;
    check_all("R10 second reset");
    rdv = rd_data;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule